// File: doc/BRIEF.md
# Block Address Translation Array

This block maps 32-bit effective addresses onto 32-bit physical addresses for a few large memory regions that software defines. It holds two independent four-entry arrays, one serving instruction fetches and one serving data accesses. Software fills the entries through a single write port. Each entry holds:

- an effective base and a physical base;
- a length mask that sets the region size anywhere from 128 KB to 256 MB;
- privilege-valid bits for supervisor and user;
- a two-bit access-rights field.

Each lookup compares the address against every entry of its array in parallel. The translated address comes from the physical base in the high bits and from the effective address in the low bits.

The address, privilege and access kind go to the lookup port of one side. The compare and the priority select are combinational. One cycle later a registered result appears with a valid flag, a hit flag, a fault flag and the physical address. When the translation enable for that side is clear, the address passes through unchanged.

Top module: `bat_xlate`

## Requirements
- R1: While reset is held, and after it is released, every entry of both arrays is invalid, and all valid, hit and fault outputs are 0.
- R2: A request whose side has translate enable clear returns, one cycle later, valid=1, hit=0, fault=0, and a physical address equal to the effective address, whatever the entries contain.
- R3: An entry matches when effective-address bits 31:17 equal its effective base. Bits 27:17 are excluded from the compare where the corresponding length-mask bit is set (mask bit k covers address bit 17+k). A zero mask gives a 128 KB region and an all-ones mask gives a 256 MB region.
- R4: On a hit without fault, physical bits 31:17 come from the physical base where the mask bit is clear and from the effective address where it is set. Physical bits 16:0 equal effective bits 16:0.
- R5: An entry can match only when the request is from user mode and its user-valid bit is set, or from supervisor mode and its supervisor-valid bit is set.
- R6: The access-rights code is 00 for no access, 01 or 11 for read-only, and 10 for read/write. A hit raises fault for any access when the code is 00, and for a data store unless the code is 10. A faulting result has hit=1 and physical address 0.
- R7: When several entries match, the lowest-numbered one supplies the result.
- R8: A translated request that matches no entry returns valid=1, hit=0, fault=0 and physical address 0.
- R9: A write with side select 0 updates only the instruction array, and a write with side select 1 updates only the data array.
- R10: Results appear on the clock edge after the request. With no request, valid, hit and fault are 0 and the address is 0. A write is used by lookups from the next cycle on, not by a lookup in the same cycle.
- R11: The write word is laid out as: bits 44:30 effective base (address bits 31:17), bits 29:15 physical base, bits 14:4 length mask, bit 3 supervisor valid, bit 2 user valid, bits 1:0 access rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_side_i | input | 1 | Array select for the write: 0 instruction, 1 data |
| cfg_idx_i | input | 2 | Entry index to write |
| cfg_data_i | input | 45 | Entry contents (R11 layout) |
| i_req_i | input | 1 | Instruction lookup request |
| i_ea_i | input | 32 | Instruction effective address |
| i_xlate_en_i | input | 1 | Instruction translation enable |
| i_user_i | input | 1 | Instruction request from user mode |
| i_vld_o | output | 1 | Instruction result valid |
| i_hit_o | output | 1 | Instruction hit |
| i_fault_o | output | 1 | Instruction protection fault |
| i_pa_o | output | 32 | Instruction physical address |
| d_req_i | input | 1 | Data lookup request |
| d_ea_i | input | 32 | Data effective address |
| d_store_i | input | 1 | Data access is a store |
| d_xlate_en_i | input | 1 | Data translation enable |
| d_user_i | input | 1 | Data request from user mode |
| d_vld_o | output | 1 | Data result valid |
| d_hit_o | output | 1 | Data hit |
| d_fault_o | output | 1 | Data protection fault |
| d_pa_o | output | 32 | Data physical address |

## Verification
The assertions assume that request, address and enable inputs are stable across each clock edge. They therefore relate each registered result to the inputs of the cycle before through $past. They never depend on entry contents, so the offset rule holds for any mask, including masks that are not contiguous. The bench writes only contiguous low-order masks, so its region-size model stays exact. It aims random addresses at the bases of live entries so that hits, overlaps and faults occur often. It also puts writes and lookups in the same cycle to exercise the one-cycle visibility rule.

// File: rtl/bat_pkg.sv
package bat_pkg;
  parameter int ADDR_W  = 32;
  parameter int BLK_LSB = 17;
  parameter int MASK_W  = 11;
  parameter int PP_W    = 2;
  parameter int TAG_W   = ADDR_W - BLK_LSB;

  typedef enum logic [PP_W-1:0] {
    PP_NONE = 2'b00,
    PP_RO_A = 2'b01,
    PP_RW   = 2'b10,
    PP_RO_B = 2'b11
  } bat_pp_e;

  typedef struct packed {
    logic [TAG_W-1:0]  ea_base;
    logic [TAG_W-1:0]  pa_base;
    logic [MASK_W-1:0] len_mask;
    logic              sup_ok;
    logic              usr_ok;
    logic [PP_W-1:0]   pp;
  } bat_ent_t;

  parameter int ENT_W = $bits(bat_ent_t);
endpackage

// File: rtl/bat_regs.sv
module bat_regs
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  bat_ent_t                 data_i,
  output bat_ent_t [NUM_ENT-1:0]   ent_o
);
  bat_ent_t [NUM_ENT-1:0] ent_q;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[i] <= '0;
      else if (we_i && (idx_i == IDX_W'(i)))        ent_q[i] <= data_i;
    end
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_pkg::*;
(
  input  bat_ent_t            ent_i,
  input  logic [ADDR_W-1:0]   ea_i,
  input  logic                user_i,
  output logic                match_o,
  output logic [ADDR_W-1:0]   pa_o
);
  logic [TAG_W-1:0] keep;
  logic [TAG_W-1:0] ea_tag;
  logic             allowed;

  // mask bits widen the block: those tag bits skip the compare
  assign keep    = ~{{(TAG_W-MASK_W){1'b0}}, ent_i.len_mask};
  assign ea_tag  = ea_i[ADDR_W-1:BLK_LSB];
  assign allowed = user_i ? ent_i.usr_ok : ent_i.sup_ok;
  assign match_o = allowed && ((ea_tag & keep) == (ent_i.ea_base & keep));
  assign pa_o    = {(ent_i.pa_base & keep) | (ea_tag & ~keep), ea_i[BLK_LSB-1:0]};
endmodule

// File: rtl/bat_array.sv
module bat_array
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  bat_ent_t            data_i,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   ea_i,
  input  logic                xlate_en_i,
  input  logic                user_i,
  input  logic                store_i,
  output logic                vld_o,
  output logic                hit_o,
  output logic                fault_o,
  output logic [ADDR_W-1:0]   pa_o
);
  bat_ent_t [NUM_ENT-1:0] ents;
  logic [NUM_ENT-1:0]     match;
  logic [ADDR_W-1:0]      pa_c [NUM_ENT];

  logic              sel_hit;
  logic [ADDR_W-1:0] sel_pa;
  logic [PP_W-1:0]   sel_pp;
  logic              fault_c;

  logic              vld_d, hit_d, fault_d;
  logic [ADDR_W-1:0] pa_d;
  logic              vld_q, hit_q, fault_q;
  logic [ADDR_W-1:0] pa_q;

  bat_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .idx_i  (idx_i),
    .data_i (data_i),
    .ent_o  (ents)
  );

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    bat_match u_match (
      .ent_i   (ents[i]),
      .ea_i    (ea_i),
      .user_i  (user_i),
      .match_o (match[i]),
      .pa_o    (pa_c[i])
    );
  end

  // descending scan: lowest index written last wins
  always_comb begin
    sel_hit = 1'b0;
    sel_pa  = '0;
    sel_pp  = PP_NONE;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit = 1'b1;
        sel_pa  = pa_c[i];
        sel_pp  = ents[i].pp;
      end
    end
  end

  assign fault_c = sel_hit &&
                   ((sel_pp == PP_NONE) || (store_i && (sel_pp != PP_RW)));

  always_comb begin
    vld_d   = req_i;
    hit_d   = 1'b0;
    fault_d = 1'b0;
    pa_d    = '0;
    if (req_i) begin
      if (!xlate_en_i) begin
        pa_d = ea_i;
      end else if (fault_c) begin
        hit_d   = 1'b1;
        fault_d = 1'b1;
      end else if (sel_hit) begin
        hit_d = 1'b1;
        pa_d  = sel_pa;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      vld_q   <= vld_d;
      hit_q   <= hit_d;
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  assign vld_o   = vld_q;
  assign hit_o   = hit_q;
  assign fault_o = fault_q;
  assign pa_o    = pa_q;
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_side_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ENT_W-1:0]  cfg_data_i,
  input  logic              i_req_i,
  input  logic [ADDR_W-1:0] i_ea_i,
  input  logic              i_xlate_en_i,
  input  logic              i_user_i,
  output logic              i_vld_o,
  output logic              i_hit_o,
  output logic              i_fault_o,
  output logic [ADDR_W-1:0] i_pa_o,
  input  logic              d_req_i,
  input  logic [ADDR_W-1:0] d_ea_i,
  input  logic              d_store_i,
  input  logic              d_xlate_en_i,
  input  logic              d_user_i,
  output logic              d_vld_o,
  output logic              d_hit_o,
  output logic              d_fault_o,
  output logic [ADDR_W-1:0] d_pa_o
);
  localparam int NUM_SIDES = 2;

  logic              req_s   [NUM_SIDES];
  logic [ADDR_W-1:0] ea_s    [NUM_SIDES];
  logic              en_s    [NUM_SIDES];
  logic              user_s  [NUM_SIDES];
  logic              store_s [NUM_SIDES];
  logic              vld_s   [NUM_SIDES];
  logic              hit_s   [NUM_SIDES];
  logic              fault_s [NUM_SIDES];
  logic [ADDR_W-1:0] pa_s    [NUM_SIDES];
  bat_ent_t          wr_ent;

  assign wr_ent = bat_ent_t'(cfg_data_i);

  assign req_s[0]   = i_req_i;
  assign ea_s[0]    = i_ea_i;
  assign en_s[0]    = i_xlate_en_i;
  assign user_s[0]  = i_user_i;
  assign store_s[0] = 1'b0;          // fetches never write
  assign req_s[1]   = d_req_i;
  assign ea_s[1]    = d_ea_i;
  assign en_s[1]    = d_xlate_en_i;
  assign user_s[1]  = d_user_i;
  assign store_s[1] = d_store_i;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    bat_array #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_arr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (cfg_we_i && (cfg_side_i == 1'(s))),
      .idx_i      (cfg_idx_i),
      .data_i     (wr_ent),
      .req_i      (req_s[s]),
      .ea_i       (ea_s[s]),
      .xlate_en_i (en_s[s]),
      .user_i     (user_s[s]),
      .store_i    (store_s[s]),
      .vld_o      (vld_s[s]),
      .hit_o      (hit_s[s]),
      .fault_o    (fault_s[s]),
      .pa_o       (pa_s[s])
    );
  end

  assign i_vld_o   = vld_s[0];
  assign i_hit_o   = hit_s[0];
  assign i_fault_o = fault_s[0];
  assign i_pa_o    = pa_s[0];
  assign d_vld_o   = vld_s[1];
  assign d_hit_o   = hit_s[1];
  assign d_fault_o = fault_s[1];
  assign d_pa_o    = pa_s[1];
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              i_req_i,
  input logic [ADDR_W-1:0] i_ea_i,
  input logic              i_xlate_en_i,
  input logic              i_vld_o,
  input logic              i_hit_o,
  input logic              i_fault_o,
  input logic [ADDR_W-1:0] i_pa_o,
  input logic              d_req_i,
  input logic [ADDR_W-1:0] d_ea_i,
  input logic              d_xlate_en_i,
  input logic              d_vld_o,
  input logic              d_hit_o,
  input logic              d_fault_o,
  input logic [ADDR_W-1:0] d_pa_o
);
  AST_I_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_req_i && !i_xlate_en_i) |=> (i_vld_o && !i_hit_o && !i_fault_o && i_pa_o == $past(i_ea_i))); // R2
  AST_D_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_req_i && !d_xlate_en_i) |=> (d_vld_o && !d_hit_o && !d_fault_o && d_pa_o == $past(d_ea_i))); // R2
  AST_I_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_hit_o && !i_fault_o) |-> (i_pa_o[BLK_LSB-1:0] == $past(i_ea_i[BLK_LSB-1:0]))); // R4
  AST_D_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_hit_o && !d_fault_o) |-> (d_pa_o[BLK_LSB-1:0] == $past(d_ea_i[BLK_LSB-1:0]))); // R4
  AST_I_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_fault_o |-> (i_hit_o && i_pa_o == '0)); // R6
  AST_D_FAULT_NO_PA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_fault_o |-> (d_hit_o && d_pa_o == '0)); // R6
  AST_I_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !i_req_i |=> (!i_vld_o && !i_hit_o && !i_fault_o && i_pa_o == '0)); // R10
  AST_D_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !d_req_i |=> (!d_vld_o && !d_hit_o && !d_fault_o && d_pa_o == '0)); // R10
  AST_D_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |=> d_vld_o); // R10
endmodule

bind bat_xlate bat_xlate_chk u_chk (.*);

// File: tb/bat_xlate_tb.sv
`timescale 1ns/1ps
module bat_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_side = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [44:0] cfg_data = '0;
  logic        i_req = 0, i_en = 0, i_user = 0;
  logic [31:0] i_ea = '0;
  logic        d_req = 0, d_en = 0, d_user = 0, d_st = 0;
  logic [31:0] d_ea = '0;
  logic        i_vld, i_hit, i_fault, d_vld, d_hit, d_fault;
  logic [31:0] i_pa, d_pa;

  int total = 0, bad = 0;
  string tag = "R1";
  logic [44:0] m [2][4];
  logic        e_v [2], e_h [2], e_f [2];
  logic [31:0] e_pa [2];
  bit          done = 0;

  always #2.5 clk = ~clk;

  bat_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_side_i(cfg_side), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .i_req_i(i_req), .i_ea_i(i_ea), .i_xlate_en_i(i_en), .i_user_i(i_user),
    .i_vld_o(i_vld), .i_hit_o(i_hit), .i_fault_o(i_fault), .i_pa_o(i_pa),
    .d_req_i(d_req), .d_ea_i(d_ea), .d_store_i(d_st), .d_xlate_en_i(d_en), .d_user_i(d_user),
    .d_vld_o(d_vld), .d_hit_o(d_hit), .d_fault_o(d_fault), .d_pa_o(d_pa)
  );

  // behavioural reference: region size from mask width, arithmetic on addresses
  function automatic void model(input int s, input logic req, en, user, st,
                                input logic [31:0] ea,
                                output logic v, h, f, output logic [31:0] pa);
    logic [31:0] eb, pb, size;
    logic [44:0] e;
    v = req; h = 0; f = 0; pa = '0;
    if (!req) return;
    if (!en) begin pa = ea; return; end
    for (int i = 0; i < 4; i++) begin
      e    = m[s][i];
      eb   = {e[44:30], 17'b0};
      pb   = {e[29:15], 17'b0};
      size = 32'h2_0000 << $countones(e[14:4]);
      if ((user ? e[2] : e[3]) && (ea / size == eb / size)) begin
        h = 1;
        if (e[1:0] == 2'b00 || (st && e[1:0] != 2'b10)) f = 1;
        else pa = (pb / size) * size + (ea % size);
        return;
      end
    end
  endfunction

  function automatic logic [44:0] mk(input logic [31:0] eb, pb, input int nb,
                                     input logic vs, vu, input logic [1:0] pp);
    logic [10:0] msk = 11'((32'd1 << nb) - 1);
    return {eb[31:17], pb[31:17], msk, vs, vu, pp};
  endfunction

  task automatic check_out(input int s, input logic v, h, f, input logic [31:0] pa);
    total++;
    if (v !== e_v[s] || h !== e_h[s] || f !== e_f[s] || pa !== e_pa[s]) begin
      bad++;
      $display("FAIL %s side=%0d got v%b h%b f%b pa=%h exp v%b h%b f%b pa=%h",
               tag, s, v, h, f, pa, e_v[s], e_h[s], e_f[s], e_pa[s]);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) begin
      model(0, i_req, i_en, i_user, 1'b0, i_ea, e_v[0], e_h[0], e_f[0], e_pa[0]);
      model(1, d_req, d_en, d_user, d_st, d_ea, e_v[1], e_h[1], e_f[1], e_pa[1]);
      if (cfg_we) m[cfg_side][cfg_idx] = cfg_data;
    end
    @(negedge clk);
    check_out(0, i_vld, i_hit, i_fault, i_pa);
    check_out(1, d_vld, d_hit, d_fault, d_pa);
    cfg_we = 0; i_req = 0; d_req = 0;
  endtask

  task automatic wr(input logic s, input logic [1:0] idx, input logic [44:0] dat);
    cfg_we = 1; cfg_side = s; cfg_idx = idx; cfg_data = dat;
    cyc();
  endtask

  task automatic dacc(input logic [31:0] ea, input logic en, user, st);
    d_req = 1; d_ea = ea; d_en = en; d_user = user; d_st = st;
    cyc();
  endtask

  task automatic iacc(input logic [31:0] ea, input logic en, user);
    i_req = 1; i_ea = ea; i_en = en; i_user = user;
    cyc();
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      e_v[s] = 0; e_h[s] = 0; e_f[s] = 0; e_pa[s] = '0;
      for (int i = 0; i < 4; i++) m[s][i] = '0;
    end
    // R1: outputs idle in and after reset
    tag = "R1";
    @(negedge clk); i_req = 1; d_req = 1; i_en = 1; d_en = 1; cyc();
    rst_n = 1;
    cyc();
    iacc(32'h0000_1000, 1, 0); dacc(32'h0000_1000, 1, 0, 0);
    // R2: bypass returns the effective address
    tag = "R2";
    dacc(32'hDEAD_BEEF, 0, 1, 1); iacc(32'h1234_5678, 0, 0);
    // R8: miss with nothing loaded
    tag = "R8";
    dacc(32'h8000_0000, 1, 0, 0);
    // R11 R3 R4: 128 KB region
    tag = "R11";
    wr(1, 0, mk(32'h1000_0000, 32'h8000_0000, 0, 1, 1, 2'b10));
    tag = "R4";  dacc(32'h1001_2344, 1, 0, 0);
    tag = "R3";  dacc(32'h1002_0000, 1, 0, 0); dacc(32'h0FFF_FFFC, 1, 0, 1);
    // R3: 256 MB region, keeps ea bits 27:17
    wr(1, 1, mk(32'h2000_0000, 32'h5000_0000, 11, 1, 1, 2'b10));
    dacc(32'h2FFF_FFFC, 1, 0, 1); dacc(32'h3000_0000, 1, 0, 0);
    tag = "R4";  dacc(32'h2ABC_0004, 1, 1, 0);
    // R5: supervisor-only entry
    tag = "R5";
    wr(1, 2, mk(32'h4000_0000, 32'h6000_0000, 3, 1, 0, 2'b10));
    dacc(32'h4008_0010, 1, 1, 0); dacc(32'h4008_0010, 1, 0, 0);
    // R6: rights
    tag = "R6";
    wr(1, 3, mk(32'h7000_0000, 32'h9000_0000, 2, 1, 1, 2'b01));
    dacc(32'h7004_0000, 1, 0, 0); dacc(32'h7004_0000, 1, 0, 1);
    wr(1, 3, mk(32'h7000_0000, 32'h9000_0000, 2, 1, 1, 2'b00));
    dacc(32'h7004_0000, 1, 0, 0);
    wr(1, 3, mk(32'h7000_0000, 32'h9000_0000, 2, 1, 1, 2'b11));
    dacc(32'h7000_0000, 1, 1, 1);
    wr(0, 0, mk(32'h7000_0000, 32'hA000_0000, 2, 1, 1, 2'b01));
    iacc(32'h7000_0100, 1, 0);
    wr(0, 0, mk(32'h7000_0000, 32'hA000_0000, 2, 1, 1, 2'b00));
    iacc(32'h7000_0100, 1, 0);
    // R7: overlap, index 0 beats index 1
    tag = "R7";
    wr(1, 0, mk(32'h2000_0000, 32'hC000_0000, 1, 1, 1, 2'b10));
    dacc(32'h2001_0000, 1, 0, 0); dacc(32'h2004_0000, 1, 0, 0);
    // R9: data entries invisible to fetches
    tag = "R9";
    iacc(32'h2001_0000, 1, 0); iacc(32'h4008_0010, 1, 0);
    // R10: same-cycle write uses the old entry, then the new one
    tag = "R10";
    cfg_we = 1; cfg_side = 1; cfg_idx = 0;
    cfg_data = mk(32'h2000_0000, 32'hE000_0000, 1, 1, 1, 2'b10);
    d_req = 1; d_ea = 32'h2001_0000; d_en = 1; d_user = 0; d_st = 0;
    cyc();
    dacc(32'h2001_0000, 1, 0, 0);
    cyc();
    // random mix (R3 R4 R5 R6 R7)
    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(7) == 0) begin
        cfg_we = 1; cfg_side = 1'($urandom); cfg_idx = 2'($urandom);
        cfg_data = mk($urandom, $urandom, $urandom_range(11), 1'($urandom), 1'($urandom), 2'($urandom));
      end
      for (int s = 0; s < 2; s++) begin
        logic [31:0] a = $urandom;
        logic [44:0] e = m[s][$urandom_range(3)];
        if ($urandom_range(3) != 0)
          a[31:17] = e[44:30] ^ ({4'b0, e[14:4]} & 15'($urandom));
        if (s == 0) begin
          i_req = ($urandom_range(7) != 0); i_ea = a; i_en = ($urandom_range(9) != 0); i_user = 1'($urandom);
        end else begin
          d_req = ($urandom_range(7) != 0); d_ea = a; d_en = ($urandom_range(9) != 0);
          d_user = 1'($urandom); d_st = 1'($urandom);
        end
      end
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R10 got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule